// File: doc/BRIEF.md
# Paged Program Sequencer

This block decides, every clock, which program word a small DSP core fetches next. It holds an 8-bit instruction pointer inside a 15-bit instruction page. Program words are 16 bits wide and sit two bytes apart in an external program store that begins at a base byte address. A start request loads an entry page and pointer and sets the core running. From then on the sequencer decodes the opcode returned for the current fetch address. It steps the pointer, follows near or far jumps and calls, returns through an eight-entry hardware call stack, discards the next word after a conditional skip whose condition holds, and halts on the stop opcode.

Far transfers do not take their page from the opcode. They copy it from a page buffer that earlier opcodes fill, either whole or one byte at a time. Filling this buffer never moves the current page. A return always restores both the page and the pointer from the stack.

Top module: `prog_seq`

## Requirements
- R1: After reset the core is halted, the pointer, page and page buffer are zero and the call stack is empty.
- R2: The fetch address is base + page*512 + pointer*2, modulo 2^24.
- R3: A start request loads the entry page and pointer, sets the core running and clears any pending skip. It takes priority over the opcode presented in that cycle.
- R4: An opcode that transfers nothing advances the pointer by one, wrapping from 255 to 0 inside the same page.
- R5: A jump (opcode bits [15:10] = 0x18, or 0x10+c when conditional) loads the pointer from bits [7:0]. When bit 8 is 0 (near), the page is unchanged.
- R6: When bit 8 of a taken jump or call is 1 (far), the page is loaded from the page buffer.
- R7: Opcode 0x20 sets the page buffer to {7'b0, bits[7:0]}. Opcode 0x21 writes bits [7:0] into buffer bits [7:0] when bit 8 is 0, or bits [6:0] into buffer bits [14:8] when bit 8 is 1. Neither changes the current page.
- R8: Conditional opcodes use condition flag c = bits [11:10]. The condition holds when that flag XOR bit 9 is 1. A jump or call whose condition fails advances the pointer by one.
- R9: A taken call (0x19, or 0x14+c when conditional) pushes the page and pointer+1 (wrapped). A return (0x1A) pops them back as both page and pointer.
- R10: The stack holds 8 entries. A call made with the stack full overwrites the oldest entry, and a return with the stack empty loads page 0 and pointer 0.
- R11: A skip (0x1C+c) advances the pointer. When its condition holds, the next opcode is discarded, with only its pointer step kept, even if it is a stop.
- R12: The stop opcode (bits [15:10] all ones) clears running and leaves the pointer on the stop word. While halted, opcodes have no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request |
| start_page_i | input | 15 | Entry page for a start |
| start_ptr_i | input | 8 | Entry pointer for a start |
| op_i | input | 16 | Opcode fetched from the current fetch address |
| flags_i | input | 4 | Condition flags |
| base_i | input | 24 | Byte base address of the program store |
| fetch_addr_o | output | 24 | Byte address of the current program word |
| running_o | output | 1 | Core is executing |

## Verification
The assertions take for granted that op_i always carries the word stored at fetch_addr_o in the same cycle, with no unknown bits, and that the entry fields are valid whenever start_i is high. The bench feeds opcodes from its own program store, indexed by the page and pointer its reference model expects. It keeps the flags fixed for the length of a run, so a condition cannot change between decode and effect. While the core is halted it presents a far jump, which lets the bench check that halted opcodes are ignored.

// File: rtl/prog_seq_pkg.sv
// Shared widths, opcode classes and the decoded-opcode record for the
// paged program sequencer. Assumes a 16-bit opcode with a 6-bit operation field.
package prog_seq_pkg;
    localparam int OP_W    = 16;
    localparam int PTR_W   = 8;
    localparam int PAGE_W  = 15;
    localparam int FLAG_W  = 4;
    localparam int SEL_W   = $clog2(FLAG_W);
    localparam int RET_W   = PAGE_W + PTR_W;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_JUMP,
        CL_CALL,
        CL_RET,
        CL_SKIP,
        CL_PBUF,
        CL_STOP
    } op_class_e;

    typedef struct packed {
        op_class_e          cls;
        logic               cond_always;
        logic               cond_inv;
        logic [SEL_W-1:0]   cond_sel;
        logic               far;
        logic               byte_mode;
        logic               byte_hi;
        logic [7:0]         imm;
    } dec_t;
endpackage

// File: rtl/seq_decode.sv
// Opcode decoder: sorts the 6-bit operation field into a sequencing class
// and extracts the condition, far bit and immediate. Purely combinational.
module seq_decode
    import prog_seq_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output dec_t            dec_o
);
    // Class and field extraction from the operation field.
    always_comb begin
        dec_o             = '0;
        dec_o.cls         = CL_NONE;
        dec_o.cond_always = 1'b0;
        dec_o.cond_inv    = op_i[9];
        dec_o.cond_sel    = op_i[10 +: SEL_W];
        dec_o.far         = op_i[8];
        dec_o.byte_mode   = 1'b0;
        dec_o.byte_hi     = op_i[8];
        dec_o.imm         = op_i[7:0];
        casez (op_i[15:10])
            6'b0100??: dec_o.cls = CL_JUMP;
            6'b0101??: dec_o.cls = CL_CALL;
            6'b011000: begin dec_o.cls = CL_JUMP; dec_o.cond_always = 1'b1; end
            6'b011001: begin dec_o.cls = CL_CALL; dec_o.cond_always = 1'b1; end
            6'b011010: dec_o.cls = CL_RET;
            6'b0111??: dec_o.cls = CL_SKIP;
            6'b100000: dec_o.cls = CL_PBUF;
            6'b100001: begin dec_o.cls = CL_PBUF; dec_o.byte_mode = 1'b1; end
            6'b111111: dec_o.cls = CL_STOP;
            default:   dec_o.cls = CL_NONE;
        endcase
    end

    // Stop must never be decoded as a transfer (R12).
    always_comb begin
        p_stop_not_xfer_r12: assert (!(op_i[15:10] == 6'h3F) || dec_o.cls == CL_STOP);
    end
endmodule

// File: rtl/seq_call_stack.sv
// Circular hardware return stack. A push when full overwrites the oldest
// entry; a pop when empty yields zero. Assumes push and pop are never
// requested in the same cycle.
module seq_call_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_data_i,
    output logic [W-1:0] pop_data_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [IDX_W-1:0] tos_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] tos_up;
    logic [IDX_W-1:0] tos_dn;

    // Wrapping index neighbours of the top of stack.
    always_comb begin
        tos_up = (tos_q == LAST) ? '0 : tos_q + 1'b1;
        tos_dn = (tos_q == '0) ? LAST : tos_q - 1'b1;
    end

    // Top-of-stack read, zero when nothing is stored.
    assign pop_data_o = (cnt_q == '0) ? '0 : mem_q[tos_q];

    // Index and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos_q <= LAST;
            cnt_q <= '0;
        end else if (pop_i) begin
            if (cnt_q != '0) begin
                tos_q <= tos_dn;
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (push_i) begin
            tos_q <= tos_up;
            if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Entry storage; a push lands one slot above the current top.
    always_ff @(posedge clk) begin
        if (push_i && !pop_i) mem_q[tos_up] <= push_data_i;
    end

    // A push into a full stack keeps it full (R10).
    p_full_push_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && cnt_q == FULL) |=> cnt_q == FULL);
    // A pop from an empty stack leaves it empty (R10).
    p_empty_pop_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/seq_fetch_addr.sv
// Forms the program byte address: base plus page and pointer scaled for
// two-byte words. Result wraps modulo the base width.
module seq_fetch_addr
    import prog_seq_pkg::*;
#(
    parameter int BASE_W = 24
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PTR_W-1:0]  ptr_i,
    output logic [BASE_W-1:0] addr_o
);
    localparam int OFF_W = PAGE_W + PTR_W + 1;
    logic [OFF_W-1:0]  offset;
    logic [BASE_W-1:0] offset_ext;

    assign offset = {page_i, ptr_i, 1'b0};

    // Size the word offset to the base width.
    generate
        if (BASE_W >= OFF_W) begin : g_widen
            assign offset_ext = {{(BASE_W - OFF_W){1'b0}}, offset};
        end else begin : g_trim
            assign offset_ext = offset[BASE_W-1:0];
        end
    endgenerate

    assign addr_o = base_i + offset_ext;
endmodule

// File: rtl/prog_seq.sv
// Paged program sequencer. Holds pointer, page, page buffer, run and skip
// state; executes one opcode per clock while running. Assumes op_i is the
// word at fetch_addr_o in the same cycle.
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int BASE_W      = 24,
    parameter int STACK_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [PAGE_W-1:0]    start_page_i,
    input  logic [PTR_W-1:0]     start_ptr_i,
    input  logic [OP_W-1:0]      op_i,
    input  logic [FLAG_W-1:0]    flags_i,
    input  logic [BASE_W-1:0]    base_i,
    output logic [BASE_W-1:0]    fetch_addr_o,
    output logic                 running_o
);
    logic              running_q, running_n;
    logic              skip_q, skip_n;
    logic [PTR_W-1:0]  ptr_q, ptr_n, ptr_inc;
    logic [PAGE_W-1:0] page_q, page_n;
    logic [PAGE_W-1:0] pbuf_q, pbuf_n;
    dec_t              dec;
    logic              exec, cond_ok, push, pop;
    logic [RET_W-1:0]  ret_word;

    seq_decode u_dec (
        .op_i  (op_i),
        .dec_o (dec)
    );

    seq_call_stack #(.DEPTH(STACK_DEPTH), .W(RET_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i ({page_q, ptr_inc}),
        .pop_data_o  (ret_word)
    );

    seq_fetch_addr #(.BASE_W(BASE_W)) u_addr (
        .base_i (base_i),
        .page_i (page_q),
        .ptr_i  (ptr_q),
        .addr_o (fetch_addr_o)
    );

    assign running_o = running_q;

    // Qualify the current opcode and evaluate its condition.
    always_comb begin
        exec    = running_q && !skip_q && !start_i;
        cond_ok = dec.cond_always || (flags_i[dec.cond_sel] ^ dec.cond_inv);
        ptr_inc = ptr_q + 1'b1;
        push    = exec && dec.cls == CL_CALL && cond_ok;
        pop     = exec && dec.cls == CL_RET;
    end

    // Next-state selection for pointer, page, page buffer, run and skip.
    always_comb begin
        ptr_n     = ptr_q;
        page_n    = page_q;
        pbuf_n    = pbuf_q;
        running_n = running_q;
        skip_n    = skip_q;
        if (start_i) begin
            ptr_n     = start_ptr_i;
            page_n    = start_page_i;
            running_n = 1'b1;
            skip_n    = 1'b0;
        end else if (running_q) begin
            if (skip_q) begin
                ptr_n  = ptr_inc;
                skip_n = 1'b0;
            end else begin
                unique case (dec.cls)
                    CL_JUMP, CL_CALL: begin
                        if (cond_ok) begin
                            ptr_n = dec.imm;
                            if (dec.far) page_n = pbuf_q;
                        end else begin
                            ptr_n = ptr_inc;
                        end
                    end
                    CL_RET: begin
                        {page_n, ptr_n} = ret_word;
                    end
                    CL_SKIP: begin
                        ptr_n  = ptr_inc;
                        skip_n = cond_ok;
                    end
                    CL_PBUF: begin
                        ptr_n = ptr_inc;
                        if (!dec.byte_mode)
                            pbuf_n = {{(PAGE_W - 8){1'b0}}, dec.imm};
                        else if (dec.byte_hi)
                            pbuf_n[PAGE_W-1:8] = dec.imm[PAGE_W-9:0];
                        else
                            pbuf_n[7:0] = dec.imm;
                    end
                    CL_STOP: begin
                        running_n = 1'b0;
                    end
                    default: begin
                        ptr_n = ptr_inc;
                    end
                endcase
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            skip_q    <= 1'b0;
            ptr_q     <= '0;
            page_q    <= '0;
            pbuf_q    <= '0;
        end else begin
            running_q <= running_n;
            skip_q    <= skip_n;
            ptr_q     <= ptr_n;
            page_q    <= page_n;
            pbuf_q    <= pbuf_n;
        end
    end

    // Start loads the entry point and runs (R3).
    p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> running_o && ptr_q == $past(start_ptr_i) && page_q == $past(start_page_i));
    // A near transfer leaves the page alone (R5).
    p_near_keeps_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (dec.cls == CL_JUMP || dec.cls == CL_CALL) && !dec.far) |=> page_q == $past(page_q));
    // Page buffer loads never move the page (R7).
    p_pbuf_keeps_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.cls == CL_PBUF) |=> page_q == $past(page_q));
    // A discarded opcode only steps the pointer (R11).
    p_skip_discards_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && skip_q && !start_i) |=>
            running_o && page_q == $past(page_q) && ptr_q == $past(ptr_inc) && !skip_q);
    // Stop halts the core (R12).
    p_stop_halts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && dec.cls == CL_STOP) |=> !running_o && ptr_q == $past(ptr_q));
    // A halted core holds its position until started (R12).
    p_idle_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_q && !start_i) |=> !running_o && $stable(ptr_q) && $stable(page_q));
endmodule

// File: tb/prog_seq_bench.sv
// Bench for prog_seq: a behavioural reference model (queue stack, integer
// state, associative program store) compared against the ports every clock.
module prog_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [14:0] start_page_i = '0;
    logic [7:0]  start_ptr_i = '0;
    logic [15:0] op_i = '0;
    logic [3:0]  flags_i = 4'b0101;
    logic [23:0] base_i = 24'h010000;
    logic [23:0] fetch_addr_o;
    logic        running_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    int m_run, m_skip, m_ptr, m_page, m_pbuf;
    int stk[$];
    logic [15:0] prog[int];

    prog_seq u_prog_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_page_i(start_page_i),
        .start_ptr_i(start_ptr_i), .op_i(op_i), .flags_i(flags_i), .base_i(base_i),
        .fetch_addr_o(fetch_addr_o), .running_o(running_o)
    );

    always #4 clk = ~clk;

    function automatic logic [15:0] mk(int op6, int inv, int b8, int imm);
        return {op6[5:0], inv[0], b8[0], imm[7:0]};
    endfunction

    function automatic int exp_addr();
        return (int'(base_i) + m_page * 512 + m_ptr * 2) & 24'hFFFFFF;
    endfunction

    function automatic logic [15:0] fetch_op(int pg, int pt);
        int k = pg * 256 + pt;
        return prog.exists(k) ? prog[k] : 16'h0000;
    endfunction

    task automatic check(string tag, int act, int expv);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Reference model: advance one clock with the given inputs.
    task automatic model_step(bit st, int sp, int sptr, int op, int flags);
        int op6, cnd, im, far_b, inv;
        op6 = (op >> 10) & 63; im = op & 255; far_b = (op >> 8) & 1; inv = (op >> 9) & 1;
        cnd = ((flags >> (op6 & 3)) & 1) ^ inv;
        if (st) begin
            m_run = 1; m_page = sp; m_ptr = sptr; m_skip = 0;
        end else if (m_run != 0) begin
            if (m_skip != 0) begin
                m_ptr = (m_ptr + 1) & 255; m_skip = 0;
            end else if (op6 == 63) begin
                m_run = 0;
            end else if ((op6 >= 16 && op6 <= 23) || op6 == 24 || op6 == 25) begin
                bit is_call = (op6 >= 20 && op6 <= 23) || op6 == 25;
                bit take = (op6 == 24 || op6 == 25) ? 1'b1 : cnd[0];
                if (take) begin
                    if (is_call) begin
                        stk.push_back(m_page * 256 + ((m_ptr + 1) & 255));
                        if (stk.size() > 8) void'(stk.pop_front());
                    end
                    m_ptr = im;
                    if (far_b != 0) m_page = m_pbuf;
                end else m_ptr = (m_ptr + 1) & 255;
            end else if (op6 == 26) begin
                int r = (stk.size() == 0) ? 0 : stk.pop_back();
                m_page = r >> 8; m_ptr = r & 255;
            end else if (op6 >= 28 && op6 <= 31) begin
                m_ptr = (m_ptr + 1) & 255; m_skip = cnd;
            end else if (op6 == 32) begin
                m_pbuf = im; m_ptr = (m_ptr + 1) & 255;
            end else if (op6 == 33) begin
                if (far_b != 0) m_pbuf = (m_pbuf & 255) | ((im & 127) << 8);
                else m_pbuf = (m_pbuf & 32512) | im;
                m_ptr = (m_ptr + 1) & 255;
            end else m_ptr = (m_ptr + 1) & 255;
        end
    endtask

    // One clock: compare ports against the model, then drive and predict.
    task automatic step(bit st, int sp, int sptr, string tag);
        logic [15:0] op;
        @(negedge clk);
        check({tag, " running"}, int'(running_o), m_run);
        check({tag, " fetch"}, int'(fetch_addr_o), exp_addr());
        op = (m_run != 0) ? fetch_op(m_page, m_ptr) : mk(24, 0, 1, 8'h55);
        start_i = st; start_page_i = sp[14:0]; start_ptr_i = sptr[7:0]; op_i = op;
        model_step(st, sp, sptr, int'(op), int'(flags_i));
    endtask

    task automatic run_out(string tag);
        for (int i = 0; i < 80 && m_run != 0; i++) step(0, 0, 0, tag);
        step(0, 0, 0, {tag, " R12 halted"});
        step(0, 0, 0, {tag, " R12 halted"});
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_run = 0; m_skip = 0; m_ptr = 0; m_page = 0; m_pbuf = 0;
        // Scenario A, page 3: page buffer loads, near/far, skip, conditions, wrap.
        prog[3*256 + 8'h10] = mk(32, 0, 0, 8'h05);
        prog[3*256 + 8'h11] = mk(33, 0, 1, 8'h01);
        prog[3*256 + 8'h12] = mk(24, 0, 0, 8'h40);
        prog[3*256 + 8'h40] = mk(25, 0, 1, 8'h20);
        prog[261*256 + 8'h20] = mk(28, 0, 0, 0);
        prog[261*256 + 8'h21] = 16'hFC00;
        prog[261*256 + 8'h22] = mk(29, 0, 0, 0);
        prog[261*256 + 8'h23] = mk(26, 0, 0, 0);
        prog[3*256 + 8'h41] = mk(19, 0, 0, 8'h80);
        prog[3*256 + 8'h42] = mk(21, 0, 0, 8'h90);
        prog[3*256 + 8'h43] = mk(20, 0, 0, 8'h90);
        prog[3*256 + 8'h90] = mk(18, 0, 0, 8'hFE);
        prog[3*256 + 8'h00] = mk(26, 0, 0, 0);
        prog[3*256 + 8'h44] = 16'hFC00;
        // Inverted conditions on page 261.
        prog[261*256 + 8'h30] = mk(16, 1, 0, 8'h70);
        prog[261*256 + 8'h31] = mk(17, 1, 0, 8'h21);
        // Scenario B, page 7: ten nested calls, then returns past empty.
        for (int k = 0; k < 10; k++) begin
            prog[7*256 + 2*k] = mk(25, 0, 0, 2*k + 2);
            prog[7*256 + 2*k + 1] = mk(26, 0, 0, 0);
        end
        prog[7*256 + 20] = mk(26, 0, 0, 0);
        prog[0] = 16'hFC00;

        repeat (3) @(negedge clk);
        check("R1 running after reset", int'(running_o), 0);
        check("R1 fetch after reset", int'(fetch_addr_o), 24'h010000);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, "R1 R12 idle ignores opcode");
        step(0, 0, 0, "R1 R12 idle ignores opcode");

        // R3 R4 R5 R6 R7 R8 R9 R11: scenario A.
        step(1, 3, 8'h10, "R3 start");
        run_out("R4 R5 R6 R7 R8 R9 R11 scenario A");
        check("R12 stop holds pointer", int'(fetch_addr_o), 24'h010000 + 3*512 + 8'h44*2);

        // R10: overflow drops the oldest return, empty pop gives page 0 pointer 0.
        step(1, 7, 0, "R3 start B");
        run_out("R9 R10 scenario B");
        check("R10 empty return lands on zero", int'(fetch_addr_o), 24'h010000);

        // R3: a start in mid-run overrides the opcode of that cycle.
        step(1, 3, 8'h10, "R3 start C");
        step(0, 0, 0, "R7 C");
        step(0, 0, 0, "R7 C");
        step(1, 261, 8'h30, "R3 restart wins");
        run_out("R8 inverted conditions");
        check("R8 inverted jump reached stop", int'(fetch_addr_o), 24'h010000 + 261*512 + 8'h21*2);

        // R2: base change while halted, including wrap at 2^24.
        base_i = 24'hFFFF00;
        step(0, 0, 0, "R2 new base");
        check("R2 wrapped address", int'(fetch_addr_o), (24'hFFFF00 + 261*512 + 8'h21*2) & 24'hFFFFFF);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule